// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block sits on the controller side of a 32-bit SDRAM data bus. The bus is built from four byte-wide devices that are programmed for single-word bursts. A request carries one 16-byte-aligned line address. The block turns it into one row activate, a programmable number of NOP cycles, and four single-word column reads on back-to-back cycles. The last of the four reads carries auto-precharge. After it, the block holds the command bus at NOP for a programmable precharge wait.

The block drives the command pins and the bank-select pins, and it time-multiplexes the row and column onto one address bus. The read path has a fixed CAS latency. The four returning words are registered and handed out one per cycle, and a done pulse marks the fourth word. The row-to-column delay and the precharge wait are sampled from configuration inputs when a request is accepted, and they stay fixed for that access.

The byte address is laid out as {bank, row, column, byte}. The column field addresses 32-bit words.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins show NOP (cs,ras,cas,we = 0,1,1,1), `req_ready` is high, and `rd_valid` and `rd_done` are low.
- R2: When a request is accepted (`req_valid` and `req_ready` both high at a rising edge), the next cycle drives ACTIVATE (0,0,1,1). In that cycle the address bus carries the row field `req_addr[23:11]` and the bank pins carry `req_addr[25:24]`.
- R3: When `cfg_rcd` holds a value v at acceptance, exactly v NOP cycles lie between the ACTIVATE cycle and the first column read.
- R4: Four column reads (0,1,0,1) follow on consecutive cycles. Address bit 10 is low on the first three and high on the fourth, which marks auto-precharge. The bank pins keep the value they had during ACTIVATE.
- R5: Column read k (k = 0..3) carries word column `{req_addr[10:4], k}` on address bits 8:0. This means the two low word bits of the request are ignored. Address bits 12:11 and 9 are zero.
- R6: When `cfg_tpc` holds a value t at acceptance, the t+1 cycles after the auto-precharge read carry NOP, and `req_ready` stays low from the ACTIVATE cycle to the end of that wait.
- R7: The data on `sd_dq` is sampled CAS_LAT cycles after each column read is driven. It appears on `rd_data` with `rd_valid` high exactly CAS_LAT+1 cycles after that read's cycle, and the four words come out in column order.
- R8: `rd_done` is high together with the fourth `rd_valid` of an access, and at no other time.
- R9: `req_valid` raised while `req_ready` is low starts no access: no extra command appears and the running sequence is unchanged.
- R10: Changing `cfg_rcd` or `cfg_tpc` during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all logic uses the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle with no data in flight; a request is taken when both are high |
| req_addr | input | 26 | Byte address of the 16-byte line, {bank, row, column, byte} |
| cfg_rcd | input | 2 | Activate-to-read delay code, v gives v+1 cycles |
| cfg_tpc | input | 2 | Precharge wait code, t gives t+1 NOP cycles |
| rd_valid | output | 1 | One read word valid on rd_data |
| rd_data | output | 32 | Captured read word |
| rd_done | output | 1 | Marks the fourth word of the access |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column address; bit 10 marks auto-precharge on reads |
| sd_dq | input | 32 | Data from the memory devices |

## Verification
The bench builds the block with a CAS latency of 3 and the default 2-bit delay codes, so it can drive all four activate-to-read delays and all four precharge waits. With that latency, the last word returns after the short precharge waits have already ended. The data drain therefore holds off the next request in some accesses, while the precharge counter does so in others. The accesses include a misaligned request, the top row and column, and both corners of the bank field. A small memory model answers column reads from the row it latched on ACTIVATE, so the bench checks the data, the address multiplexing and the latency together.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // Command on {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sd_cmd_t;
  localparam sd_cmd_t SD_NOP  = 4'b0111;
  localparam sd_cmd_t SD_ACT  = 4'b0011;
  localparam sd_cmd_t SD_READ = 4'b0101;

  // Phase of the access as seen on the pins in the current cycle
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACT  = 3'd1,
    PH_RCD  = 3'd2,
    PH_COL  = 3'd3,
    PH_PRE  = 3'd4
  } phase_e;

endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int RCD_W  = 2,
  parameter int TPC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RCD_W-1:0]  cfg_rcd,
  input  logic [TPC_W-1:0]  cfg_tpc,
  input  logic              drain_busy,
  output logic              req_ready,
  output phase_e            phase,
  output logic              iss_act,
  output logic              iss_rd,
  output logic              iss_ap,
  output logic [1:0]        word_idx,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int CNT_W = (TPC_W > RCD_W) ? TPC_W : RCD_W;

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [1:0]         widx_q;
  logic [RCD_W-1:0]   rcd_q;
  logic [TPC_W-1:0]   tpc_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               accept;

  assign req_ready = (ph_q == PH_IDLE) && !drain_busy;
  assign accept    = req_valid && req_ready;
  assign phase     = ph_q;
  assign cur_addr  = accept ? req_addr : addr_q;

  // Strobes for the command that goes on the pins in the next cycle
  assign iss_act  = accept;
  assign iss_rd   = ((ph_q == PH_ACT) && (rcd_q == '0)) ||
                    ((ph_q == PH_RCD) && (cnt_q == '0)) ||
                    ((ph_q == PH_COL) && (widx_q != 2'd3));
  assign word_idx = (ph_q == PH_COL) ? widx_q + 2'd1 : 2'd0;
  assign iss_ap   = iss_rd && (word_idx == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      widx_q <= '0;
      rcd_q  <= '0;
      tpc_q  <= '0;
      addr_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            ph_q   <= PH_ACT;
            addr_q <= req_addr;
            rcd_q  <= cfg_rcd;
            tpc_q  <= cfg_tpc;
          end
        end
        PH_ACT: begin
          if (rcd_q == '0) begin
            ph_q   <= PH_COL;
            widx_q <= '0;
          end else begin
            ph_q  <= PH_RCD;
            cnt_q <= CNT_W'(rcd_q) - 1'b1;
          end
        end
        PH_RCD: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_COL;
            widx_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_COL: begin
          if (widx_q == 2'd3) begin
            ph_q  <= PH_PRE;
            cnt_q <= CNT_W'(tpc_q);
          end else begin
            widx_q <= widx_q + 2'd1;
          end
        end
        PH_PRE: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R2: the activate phase lasts a single cycle
  p_act_single_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ACT) |=> (ph_q != PH_ACT));

  // R4: after the fourth column cycle the precharge wait follows
  p_col_to_pre_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_COL && widx_q == 2'd3) |=> (ph_q == PH_PRE));

  // R9: no new access starts outside the idle phase
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |=> (ph_q != PH_ACT));

endmodule

// File: rtl/rdseq_addr_mux.sv
module rdseq_addr_mux
  import sdram_rd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int SA_W   = 13,
  parameter int AP_BIT = 10,
  parameter int ADDR_W = BA_W + ROW_W + COL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_act,
  input  logic              iss_rd,
  input  logic              iss_ap,
  input  logic [1:0]        word_idx,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [SA_W-1:0]   sd_a,
  output logic              rd_on_pins,
  output logic              ap_on_pins
);

  localparam int COL_LSB  = 2;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  logic [COL_W-1:0] col_f;
  logic [COL_W-1:0] col_word;
  logic [ROW_W-1:0] row_f;
  logic [BA_W-1:0]  bank_f;
  logic [SA_W-1:0]  sa_row;
  logic [SA_W-1:0]  sa_col;
  sd_cmd_t          cmd_q;

  assign col_f    = cur_addr[COL_LSB +: COL_W];
  assign row_f    = cur_addr[ROW_LSB +: ROW_W];
  assign bank_f   = cur_addr[BANK_LSB +: BA_W];
  assign col_word = {col_f[COL_W-1:2], word_idx};

  always_comb begin
    sa_row = '0;
    sa_row[ROW_W-1:0] = row_f;
    sa_col = '0;
    sa_col[COL_W-1:0] = col_word;
    sa_col[AP_BIT] = iss_ap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= SD_NOP;
      sd_ba      <= '0;
      sd_a       <= '0;
      rd_on_pins <= 1'b0;
      ap_on_pins <= 1'b0;
    end else begin
      rd_on_pins <= iss_rd && !iss_act;
      ap_on_pins <= iss_ap && !iss_act;
      if (iss_act) begin
        cmd_q <= SD_ACT;
        sd_a  <= sa_row;
        sd_ba <= bank_f;
      end else if (iss_rd) begin
        cmd_q <= SD_READ;
        sd_a  <= sa_col;
        sd_ba <= bank_f;
      end else begin
        cmd_q <= SD_NOP;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R4: a read without auto-precharge is always followed by another read
  p_reads_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == SD_READ && !sd_a[AP_BIT]) |=> (cmd_q == SD_READ));

  // R4: the bank pins do not move during a column read
  p_bank_held_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == SD_READ && $past(cmd_q) != SD_NOP) |-> $stable(sd_ba));

  // R6: an auto-precharge read is followed by NOP
  p_nop_after_ap_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == SD_READ && sd_a[AP_BIT]) |=> (cmd_q == SD_NOP));

endmodule

// File: rtl/rdseq_capture.sv
module rdseq_capture #(
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_on_pins,
  input  logic              ap_on_pins,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              busy
);

  logic [CAS_LAT-1:0] vpipe;
  logic [CAS_LAT-1:0] lpipe;

  assign busy = |vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe    <= '0;
      lpipe    <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      vpipe[0] <= rd_on_pins;
      lpipe[0] <= ap_on_pins;
      for (int i = 1; i < CAS_LAT; i++) begin
        vpipe[i] <= vpipe[i-1];
        lpipe[i] <= lpipe[i-1];
      end
      rd_valid <= vpipe[CAS_LAT-1];
      rd_done  <= lpipe[CAS_LAT-1];
    end
  end

  // Data register carries no reset so it maps onto plain flops
  always_ff @(posedge clk) begin
    if (vpipe[CAS_LAT-1]) rd_data <= sd_dq;
  end

  // R8: the done marker only rides on a valid word
  p_done_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> rd_valid);

  // R8: two done markers never arrive back to back
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BA_W    = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int SA_W    = 13,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 2,
  parameter int RCD_W   = 2,
  parameter int TPC_W   = 2,
  localparam int ADDR_W = BA_W + ROW_W + COL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RCD_W-1:0]  cfg_rcd,
  input  logic [TPC_W-1:0]  cfg_tpc,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [SA_W-1:0]   sd_a,
  input  logic [DATA_W-1:0] sd_dq
);

  phase_e            phase;
  logic              iss_act;
  logic              iss_rd;
  logic              iss_ap;
  logic [1:0]        word_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic              rd_on_pins;
  logic              ap_on_pins;
  logic              drain_busy;

  rdseq_ctrl #(
    .ADDR_W (ADDR_W),
    .RCD_W  (RCD_W),
    .TPC_W  (TPC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .cfg_rcd    (cfg_rcd),
    .cfg_tpc    (cfg_tpc),
    .drain_busy (drain_busy),
    .req_ready  (req_ready),
    .phase      (phase),
    .iss_act    (iss_act),
    .iss_rd     (iss_rd),
    .iss_ap     (iss_ap),
    .word_idx   (word_idx),
    .cur_addr   (cur_addr)
  );

  rdseq_addr_mux #(
    .BA_W   (BA_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .SA_W   (SA_W),
    .AP_BIT (AP_BIT),
    .ADDR_W (ADDR_W)
  ) u_amux (
    .clk        (clk),
    .rst        (rst),
    .iss_act    (iss_act),
    .iss_rd     (iss_rd),
    .iss_ap     (iss_ap),
    .word_idx   (word_idx),
    .cur_addr   (cur_addr),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_ba      (sd_ba),
    .sd_a       (sd_a),
    .rd_on_pins (rd_on_pins),
    .ap_on_pins (ap_on_pins)
  );

  rdseq_capture #(
    .DATA_W  (DATA_W),
    .CAS_LAT (CAS_LAT)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .rd_on_pins (rd_on_pins),
    .ap_on_pins (ap_on_pins),
    .sd_dq      (sd_dq),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_done    (rd_done),
    .busy       (drain_busy)
  );

  // R6: the precharge wait drives NOP on the command pins
  p_pre_is_nop_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == SD_NOP));

  // R9: while the block offers to take a request, the bus is quiet
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == SD_NOP));

endmodule

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;

  localparam int CL = 3;

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] sa;
    bit          chk_addr;
    string       tag;
  } cmd_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [1:0]  cfg_rcd = '0;
  logic [1:0]  cfg_tpc = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_done;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  logic [31:0] sd_dq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cmd_item_t   exp_cmd[$];
  logic [32:0] exp_dat[$];
  int          rd_cyc[$];

  always #4 clk = ~clk;

  sdram_rd_seq #(.CAS_LAT(CL)) u_sdram_rd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_rcd(cfg_rcd), .cfg_tpc(cfg_tpc),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq(sd_dq)
  );

  function automatic logic [31:0] mem_word(logic [1:0] b, logic [12:0] r, logic [8:0] c);
    return {b, r, c, 8'h00} ^ 32'h5A3C_96E1;
  endfunction

  // Memory model: remembers the open row per bank, answers reads after CL cycles
  logic [12:0] mrow [4];
  logic        pv [CL];
  logic [31:0] pd [CL];
  initial for (int i = 0; i < CL; i++) begin pv[i] = 1'b0; pd[i] = '0; end
  initial for (int i = 0; i < 4; i++) mrow[i] = '0;

  always @(posedge clk) begin
    pv[0] <= ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101);
    pd[0] <= mem_word(sd_ba, mrow[sd_ba], sd_a[8:0]);
    for (int i = 1; i < CL; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011) mrow[sd_ba] <= sd_a;
  end
  assign sd_dq = pv[CL-1] ? pd[CL-1] : 32'hDEAD_BEEF;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push_cmd(logic [3:0] c, logic [1:0] b, logic [12:0] a, bit ca, string t);
    cmd_item_t it;
    it.cmd = c; it.ba = b; it.sa = a; it.chk_addr = ca; it.tag = t;
    exp_cmd.push_back(it);
  endtask

  // Driver: issues one request and pushes the expected pin and data stream
  task automatic do_req(logic [25:0] addr, logic [1:0] rcd, logic [1:0] tpc, bit poke);
    logic [1:0]  b;
    logic [12:0] r;
    logic [8:0]  c;
    b = addr[25:24];
    r = addr[23:11];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #2;
    req_valid = 1'b1;
    req_addr  = addr;
    cfg_rcd   = rcd;
    cfg_tpc   = tpc;
    push_cmd(4'b0011, b, r, 1'b1, "R2");
    for (int i = 0; i < rcd; i++) push_cmd(4'b0111, b, '0, 1'b0, "R3");
    for (int k = 0; k < 4; k++) begin
      c = {addr[10:4], 2'(k)};
      push_cmd(4'b0101, b, {2'b00, (k == 3), 1'b0, c}, 1'b1, "R4/R5");
      exp_dat.push_back({(k == 3), mem_word(b, r, c)});
    end
    for (int i = 0; i <= tpc; i++) push_cmd(4'b0111, b, '0, 1'b0, "R6");
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    // R10: scramble the configuration while the access runs
    cfg_rcd = ~rcd;
    cfg_tpc = ~tpc;
    if (poke) begin
      // R9: request while busy must be ignored
      @(negedge clk); @(negedge clk);
      #2;
      req_valid = 1'b1;
      req_addr  = ~addr;
      @(negedge clk); @(negedge clk);
      #2;
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares pins and returned words against the queues
  initial begin
    cmd_item_t e;
    logic [32:0] d;
    int t;
    forever begin
      @(negedge clk);
      if (!rst) begin
        cyc++;
        if (exp_cmd.size() > 0) begin
          e = exp_cmd.pop_front();
          check(req_ready == 1'b0, e.tag, "req_ready low during access (R6)", req_ready, 0);
        end else begin
          e.cmd = 4'b0111; e.chk_addr = 1'b0; e.tag = "R9";
        end
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e.cmd, e.tag, "command",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
        if (e.chk_addr) begin
          check(sd_ba == e.ba, e.tag, "bank", sd_ba, e.ba);
          check(sd_a == e.sa, e.tag, "address", sd_a, e.sa);
        end
        if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101) rd_cyc.push_back(cyc);
        if (rd_valid) begin
          if (exp_dat.size() == 0) begin
            check(1'b0, "R7", "unexpected rd_valid", 1, 0);
          end else begin
            d = exp_dat.pop_front();
            check(rd_data == d[31:0], "R7", "read data", rd_data, d[31:0]);
            check(rd_done == d[32], "R8", "done marker", rd_done, d[32]);
            t = (rd_cyc.size() > 0) ? rd_cyc.pop_front() : -100;
            check(cyc == t + CL + 1, "R7", "data latency", cyc, t + CL + 1);
          end
        end else begin
          check(rd_done == 1'b0, "R8", "done without valid", rd_done, 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=completion");
    finish_run();
  end

  initial begin
    logic [25:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values while reset is held
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "command in reset",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    check(rd_valid == 1'b0 && rd_done == 1'b0, "R1", "read outputs in reset", {rd_valid, rd_done}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);

    do_req(26'h000_0040, 2'd0, 2'd0, 1'b0);
    do_req(26'h123_456F, 2'd1, 2'd1, 1'b0);   // misaligned column (R5)
    do_req(26'h2AB_CDE0, 2'd2, 2'd2, 1'b1);   // busy request (R9)
    do_req(26'h3FF_FFFC, 2'd3, 2'd3, 1'b0);   // top row and column
    do_req(26'h000_0000, 2'd3, 2'd0, 1'b1);
    do_req(26'h155_5554, 2'd0, 2'd3, 1'b0);
    for (int i = 0; i < 8; i++) begin
      a = 26'(32'h0456_7891 * (i + 3));
      do_req(a, 2'(i), 2'(i >> 1), i[0]);
    end

    while (exp_cmd.size() > 0 || exp_dat.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(req_ready == 1'b1, "R6", "ready after last access", req_ready, 1);
    finish_run();
  end

endmodule